// File: doc/BRIEF.md
# Multi-Processor Load-Locked Reservation Tracker

This block holds the load-locked reservation of every processor in a small shared-memory cluster. Each processor owns one slot: a valid bit plus the address of one cache line. A load-locked operation fills the slot. A later store-conditional from the same processor asks the block whether its store may go ahead. The block answers pass only if the slot still holds the line the store targets.

Reservations are optimistic, not locks. No access from any processor is ever stalled or refused. Writes can only knock reservations down. Every committed store, from any processor, is shown to the block on a single snoop port. That includes a successful conditional store's own commit. The store's line is compared against all slots at once, and every matching slot is cleared.

Each processor also has its own clear strobe. The pipeline raises it on exception or interrupt delivery, on a memory barrier, on entry to privileged mode, and on a pipeline flush. A global clear-all strobe empties the whole table. Only the cache-line part of an address is stored or compared; the offset bits inside the line are ignored everywhere.

Top module: `resv_tracker`

## Requirements
- R1: While `rst_n` is low, and after it rises, every slot is invalid, so every check returns fail.
- R2: A set from CPU i stores address bits [AW-1:log2(LINE_B)] of its address and marks the slot valid. From the next clock edge on, a check from CPU i to any address inside that same line passes.
- R3: A check fails if the CPU's own slot is invalid or holds a different line. A slot held by another CPU never makes a check pass.
- R4: A new set overwrites the CPU's previous reservation. From the next edge on, the old line fails and the new line passes.
- R5: A store commit clears, at the next edge, every valid slot whose line equals the store's line, across all CPUs at once.
- R6: The snoop compares only the line part of the address. A commit at any offset inside a reserved line clears the slot. A commit to any other line, even an adjacent one, leaves the slot intact.
- R7: A per-CPU clear invalidates only that CPU's slot at the next edge.
- R8: Clear-all invalidates every slot at the next edge.
- R9: When a set and a matching snoop hit the same slot in the same cycle, the set wins: the slot is valid with the new line afterwards.
- R10: When a set coincides with a per-CPU clear for that CPU, or with clear-all, the clear wins: the slot is invalid afterwards.
- R11: `sc_pass_o[i]` is combinational from the current slot state and is high only while `sc_chk_i[i]` is high. A check does not change any slot. A check in the same cycle as a set still sees the old state.
- R12: Under any mix of sets, checks, clears and commits, each CPU's pass result depends only on its own slot history and on the store commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_set_i | input | NCPU | Per-CPU load-locked strobe |
| ll_addr_i | input | NCPU*AW | Per-CPU load-locked physical address; CPU i in bits [i*AW +: AW] |
| sc_chk_i | input | NCPU | Per-CPU store-conditional check strobe |
| sc_addr_i | input | NCPU*AW | Per-CPU store-conditional address; CPU i in bits [i*AW +: AW] |
| sc_pass_o | output | NCPU | Per-CPU check result, 1 = conditional store may succeed |
| cpu_clr_i | input | NCPU | Per-CPU reservation clear strobe |
| st_commit_i | input | 1 | A store has committed this cycle |
| st_addr_i | input | AW | Physical address of the committed store |
| clr_all_i | input | 1 | Invalidate every reservation |

## Verification
The bench goes after the collision cases. A set meeting a snoop on the same line must survive; if the priority were reversed, a load-locked issued beside a remote store would be lost. A set meeting a per-CPU clear or clear-all must be dropped; if that priority were wrong, a reservation would live on past a flush.

The bench also probes line granularity. It commits inside a reserved line at a nonzero offset, and it commits to the adjacent line. A wrong mask would either miss the first or wrongly kill on the second.

Further cases cover a check in the same cycle as a set, repeated checks, and cross-CPU isolation. These catch a check that consumes the slot, a result that is registered a cycle late, or a compare against the wrong CPU's slot.

// File: rtl/resv_pkg.sv
package resv_pkg;

    // Per-slot action chosen each cycle, listed from lowest to highest precedence.
    typedef enum logic [1:0] {
        SLOT_HOLD = 2'd0,
        SLOT_LOAD = 2'd1,
        SLOT_DROP = 2'd2
    } slot_op_e;

    function automatic int line_off_w(input int line_bytes);
        return $clog2(line_bytes);
    endfunction

endpackage

// File: rtl/resv_line_of.sv
module resv_line_of #(
    parameter int AW     = 40,
    parameter int LINE_B = 64,
    localparam int OFF_W = resv_pkg::line_off_w(LINE_B),
    localparam int LW    = AW - OFF_W
) (
    input  logic [AW-1:0] addr_i,
    output logic [LW-1:0] line_o
);
    // Drop the byte-in-line offset; only the line number is kept.
    assign line_o = LW'(addr_i >> OFF_W);
endmodule

// File: rtl/resv_slot.sv
module resv_slot
    import resv_pkg::*;
#(
    parameter int LW = 34
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic [LW-1:0] set_line_i,
    input  logic          kill_i,
    input  logic          snp_vld_i,
    input  logic [LW-1:0] snp_line_i,
    output logic          vld_o,
    output logic [LW-1:0] line_o
);
    typedef struct packed {
        logic          vld;
        logic [LW-1:0] line;
    } slot_t;

    slot_t    slot_d, slot_q;
    slot_op_e op;

    always_comb begin
        // Explicit clear beats a new set; a new set beats a snoop hit.
        if (kill_i)
            op = SLOT_DROP;
        else if (set_i)
            op = SLOT_LOAD;
        else if (snp_vld_i && slot_q.vld && (slot_q.line == snp_line_i))
            op = SLOT_DROP;
        else
            op = SLOT_HOLD;

        slot_d = slot_q;
        case (op)
            SLOT_LOAD: begin
                slot_d.vld  = 1'b1;
                slot_d.line = set_line_i;
            end
            SLOT_DROP: slot_d.vld = 1'b0;
            default:   slot_d = slot_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= '0;
        else
            slot_q <= slot_d;
    end

    assign vld_o  = slot_q.vld;
    assign line_o = slot_q.line;
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
    parameter int NCPU   = 4,
    parameter int AW     = 40,
    parameter int LINE_B = 64,
    localparam int OFF_W = resv_pkg::line_off_w(LINE_B),
    localparam int LW    = AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCPU-1:0]   ll_set_i,
    input  logic [NCPU*AW-1:0] ll_addr_i,
    input  logic [NCPU-1:0]   sc_chk_i,
    input  logic [NCPU*AW-1:0] sc_addr_i,
    output logic [NCPU-1:0]   sc_pass_o,
    input  logic [NCPU-1:0]   cpu_clr_i,
    input  logic              st_commit_i,
    input  logic [AW-1:0]     st_addr_i,
    input  logic              clr_all_i
);
    logic [LW-1:0]   snp_line;
    logic [NCPU-1:0] resv_vld;

    resv_line_of #(.AW(AW), .LINE_B(LINE_B)) u_snp_line (
        .addr_i (st_addr_i),
        .line_o (snp_line)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        logic [LW-1:0] set_line;
        logic [LW-1:0] chk_line;
        logic [LW-1:0] held_line;

        resv_line_of #(.AW(AW), .LINE_B(LINE_B)) u_set_line (
            .addr_i (ll_addr_i[i*AW +: AW]),
            .line_o (set_line)
        );

        resv_line_of #(.AW(AW), .LINE_B(LINE_B)) u_chk_line (
            .addr_i (sc_addr_i[i*AW +: AW]),
            .line_o (chk_line)
        );

        resv_slot #(.LW(LW)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (ll_set_i[i]),
            .set_line_i (set_line),
            .kill_i     (cpu_clr_i[i] | clr_all_i),
            .snp_vld_i  (st_commit_i),
            .snp_line_i (snp_line),
            .vld_o      (resv_vld[i]),
            .line_o     (held_line)
        );

        assign sc_pass_o[i] = sc_chk_i[i] & resv_vld[i] & (held_line == chk_line);
    end
endmodule

// File: rtl/resv_tracker_chk.sv
module resv_tracker_chk #(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NCPU-1:0] ll_set_i,
    input logic [NCPU-1:0] cpu_clr_i,
    input logic            clr_all_i,
    input logic [NCPU-1:0] sc_chk_i,
    input logic [NCPU-1:0] sc_pass_o,
    input logic [NCPU-1:0] resv_vld
);
    // R11: no pass without a check
    p_pass_needs_chk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_pass_o & ~sc_chk_i) == '0);

    // R8: clear-all empties the table
    p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all_i |=> (resv_vld == '0));

    for (genvar i = 0; i < NCPU; i++) begin : g_chk
        // R7 / R10: explicit clear wins
        p_cpu_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_clr_i[i] |=> !resv_vld[i]);

        // R2: an unopposed set leaves a valid slot
        p_set_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ll_set_i[i] && !cpu_clr_i[i] && !clr_all_i) |=> resv_vld[i]);

        // R3: a pass needs a live reservation
        p_pass_needs_vld_r3: assert property (@(posedge clk) disable iff (!rst_n)
            sc_pass_o[i] |-> resv_vld[i]);

        // R12: a slot only becomes valid through its own CPU's set
        p_only_own_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(resv_vld[i]) |-> $past(ll_set_i[i]));
    end
endmodule

bind resv_tracker resv_tracker_chk #(.NCPU(NCPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ll_set_i  (ll_set_i),
    .cpu_clr_i (cpu_clr_i),
    .clr_all_i (clr_all_i),
    .sc_chk_i  (sc_chk_i),
    .sc_pass_o (sc_pass_o),
    .resv_vld  (resv_vld)
);

// File: tb/sim_resv_tracker.sv
module sim_resv_tracker;
    localparam int N  = 4;
    localparam int AW = 40;
    localparam int LB = 64;
    localparam int OW = 6;
    localparam int LW = AW - OW;
    localparam logic [AW-1:0] BASE = 40'h12_3400_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    ll_set = '0;
    logic [N*AW-1:0] ll_addr = '0;
    logic [N-1:0]    sc_chk = '0;
    logic [N*AW-1:0] sc_addr = '0;
    logic [N-1:0]    sc_pass;
    logic [N-1:0]    cpu_clr = '0;
    logic            st_commit = 1'b0;
    logic [AW-1:0]   st_addr = '0;
    logic            clr_all = 1'b0;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string tag = "R1";

    bit            mv [N];
    logic [LW-1:0] ml [N];

    always #2 clk = ~clk;

    resv_tracker #(.NCPU(N), .AW(AW), .LINE_B(LB)) u0 (
        .clk(clk), .rst_n(rst_n), .ll_set_i(ll_set), .ll_addr_i(ll_addr),
        .sc_chk_i(sc_chk), .sc_addr_i(sc_addr), .sc_pass_o(sc_pass),
        .cpu_clr_i(cpu_clr), .st_commit_i(st_commit), .st_addr_i(st_addr),
        .clr_all_i(clr_all)
    );

    function automatic logic [AW-1:0] mk(input int line, input int off);
        return BASE + AW'(line) * AW'(LB) + AW'(off);
    endfunction

    function automatic logic [LW-1:0] lof(input logic [AW-1:0] a);
        return LW'(a >> OW);
    endfunction

    function automatic logic [N-1:0] exp_pass();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++)
            e[i] = sc_chk[i] && mv[i] && (ml[i] == lof(sc_addr[i*AW +: AW]));
        return e;
    endfunction

    function automatic void model_step();
        for (int i = 0; i < N; i++) begin
            if (clr_all || cpu_clr[i]) mv[i] = 0;
            else if (ll_set[i]) begin
                mv[i] = 1;
                ml[i] = lof(ll_addr[i*AW +: AW]);
            end else if (st_commit && mv[i] && ml[i] == lof(st_addr)) mv[i] = 0;
        end
    endfunction

    task automatic idle();
        ll_set = '0; sc_chk = '0; cpu_clr = '0; st_commit = 0; clr_all = 0;
    endtask

    // Caller drives inputs right after a falling edge; this checks, clocks, updates.
    task automatic cycle();
        logic [N-1:0] e;
        #1;
        e = exp_pass();
        checks++;
        if (sc_pass !== e) begin
            errors++;
            $display("FAIL %s: sc_pass actual=%b expected=%b", tag, sc_pass, e);
        end
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mv[i] = 0;
        end else model_step();
        @(negedge clk);
        idle();
    endtask

    task automatic set(input int c, input int line, input int off);
        ll_set[c] = 1'b1;
        ll_addr[c*AW +: AW] = mk(line, off);
    endtask

    task automatic chk(input int c, input int line, input int off);
        sc_chk[c] = 1'b1;
        sc_addr[c*AW +: AW] = mk(line, off);
    endtask

    task automatic chk_all(input int line, input int off);
        for (int i = 0; i < N; i++) chk(i, line, off);
    endtask

    task automatic commit(input int line, input int off);
        st_commit = 1'b1;
        st_addr = mk(line, off);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < N; i++) begin mv[i] = 0; ml[i] = '0; end
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        chk_all(0, 0); cycle();
        rst_n = 1'b1;
        chk_all(0, 0); cycle();

        // R2: set then check anywhere in the line
        tag = "R2";
        set(0, 1, 0); cycle();
        chk(0, 1, 63); cycle();
        chk(0, 1, 17); cycle();

        // R3: wrong line, empty slot, other CPU's slot
        tag = "R3";
        chk(0, 2, 0); chk(1, 1, 0); cycle();

        // R4: overwrite
        tag = "R4";
        set(0, 2, 8); cycle();
        chk(0, 1, 0); cycle();
        chk(0, 2, 40); cycle();

        // R5: commit clears all matching slots
        tag = "R5";
        set(1, 3, 0); set(2, 3, 9); set(3, 4, 0); cycle();
        chk_all(3, 0); cycle();
        commit(3, 5); cycle();
        chk(1, 3, 0); chk(2, 3, 0); chk(3, 4, 1); chk(0, 2, 0); cycle();

        // R6: adjacent line does not clear, same line any offset does
        tag = "R6";
        commit(5, 0); cycle();
        chk(3, 4, 2); cycle();
        commit(3, 63); cycle();
        chk(3, 4, 2); cycle();
        commit(4, 63); cycle();
        chk(3, 4, 2); cycle();

        // R7: per-CPU clear
        tag = "R7";
        for (int i = 0; i < N; i++) set(i, 6, i);
        cycle();
        cpu_clr[2] = 1'b1; cycle();
        chk_all(6, 0); cycle();

        // R8: clear-all
        tag = "R8";
        clr_all = 1'b1; cycle();
        chk_all(6, 0); cycle();

        // R9: set beats snoop
        tag = "R9";
        set(0, 7, 0); cycle();
        set(0, 7, 4); commit(7, 0); cycle();
        chk(0, 7, 0); cycle();

        // R10: clear beats set
        tag = "R10";
        set(1, 7, 0); cpu_clr[1] = 1'b1; cycle();
        chk(1, 7, 0); cycle();
        set(2, 7, 0); clr_all = 1'b1; cycle();
        chk(2, 7, 0); chk(0, 7, 0); cycle();

        // R11: check is combinational and non-destructive
        tag = "R11";
        set(3, 8, 0); cycle();
        chk(3, 8, 0); cycle();
        chk(3, 8, 0); cycle();
        sc_addr[3*AW +: AW] = mk(8, 0); cycle();
        chk(3, 8, 0); set(3, 9, 0); cycle();
        chk(3, 9, 0); cycle();

        // R12: random mix
        tag = "R12";
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(4) == 0) set(i, $urandom_range(5), $urandom_range(63));
                if ($urandom_range(1) == 0) chk(i, $urandom_range(5), $urandom_range(63));
                if ($urandom_range(15) == 0) cpu_clr[i] = 1'b1;
            end
            if ($urandom_range(3) == 0) commit($urandom_range(5), $urandom_range(63));
            if ($urandom_range(199) == 0) clr_all = 1'b1;
            cycle();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule